// File: doc/BRIEF.md
# Shift-and-Add Address Unit

This unit forms a scaled-index sum of the kind used in address arithmetic: one 64-bit operand is moved left by a small amount and added to a 64-bit base. The shift amount comes from a 2-bit immediate with a built-in bias of one, so the operand always moves by 1 to 4 places and never by zero. Bits pushed out past the top are lost, and the sum wraps modulo 2^64.

The operand to be shifted can be taken in three ways, chosen by a 2-bit select. It can be used at its full 64-bit width. It can be reduced to its low 32-bit word with bit 31 copied into the upper half. It can be reduced to its low 32-bit word with the upper half cleared. The word forms are applied before the shift.

A record flag requests a 4-bit condition field. This field compares the signed result with zero. Sum and condition field are both registered and appear one clock after a valid strobe.

Top module: `saa_unit`

## Requirements
- R1: With select 2'b00, the sum equals base + (opnd << (sh+1)) modulo 2^64, where opnd is the full 64-bit operand.
- R2: With select 2'b01, opnd is the low 32 bits of the operand with bits 63:32 all equal to bit 31, and the sum is formed as in R1.
- R3: With select 2'b10, opnd is the low 32 bits of the operand with bits 63:32 cleared, and the sum is formed as in R1.
- R4: Select 2'b11 behaves exactly like select 2'b00.
- R5: The 2-bit immediate sh gives shifts of 1, 2, 3 or 4 places. Vacated low bits are zero and bits shifted past bit 63 are discarded, so sum bit 0 always equals base bit 0.
- R6: A strobe on vld_in sampled at a rising edge gives out_vld high and the new sum during the following cycle only. While no strobe arrives, sum_q holds its last value.
- R7: When rec is 1 with the strobe, cond_vld goes high with out_vld. cond_q bit 3 is set for a negative result, bit 2 for a positive result and bit 1 for a zero result, so exactly one of them is set. Bit 0 is always 0.
- R8: When rec is 0 with the strobe, cond_vld stays low and cond_q is 0.
- R9: While rst_n is low at a rising edge, sum_q, cond_q, out_vld and cond_vld all become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| vld_in | input | 1 | Operation strobe |
| base_in | input | 64 | Addend that is not shifted |
| idx_in | input | 64 | Operand that is extended and shifted |
| sh_in | input | 2 | Shift immediate; actual shift is sh_in+1 |
| sel_in | input | 2 | Operand form: 00 full, 01 signed word, 10 unsigned word, 11 full |
| rec_in | input | 1 | Request the condition field |
| sum_q | output | 64 | Registered sum |
| out_vld | output | 1 | Sum valid for one cycle |
| cond_q | output | 4 | {negative, positive, zero, 0} of the sum |
| cond_vld | output | 1 | Condition field valid for one cycle |

## Verification
Every result (sum, out_vld, cond_q and cond_vld) is due exactly one rising edge after the edge that samples the strobe, with no further stage. The bench drives each operation on a falling edge and holds the strobe for one cycle. It then reads all outputs on the next falling edge, after the single capturing edge and before any later one. One idle cycle follows each operation to confirm that the valid flags drop and the sum holds.

// File: rtl/saa_pkg.sv
package saa_pkg;

  typedef enum logic [1:0] {
    SEL_FULL  = 2'b00,
    SEL_SWORD = 2'b01,
    SEL_UWORD = 2'b10,
    SEL_ALT   = 2'b11
  } saa_sel_e;

  localparam int unsigned CC_W   = 4;
  localparam int unsigned CC_NEG = 3;
  localparam int unsigned CC_POS = 2;
  localparam int unsigned CC_ZER = 1;
  localparam int unsigned CC_SO  = 0;

endpackage

// File: rtl/saa_extend.sv
module saa_extend
  import saa_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0] src,
  input  saa_sel_e        sel,
  output logic [XLEN-1:0] opnd
);
  localparam int unsigned HALF = XLEN / 2;

  // widen the low half, replicating fill into the upper half
  function automatic logic [XLEN-1:0] widen_word(input logic [XLEN-1:0] v,
                                                 input logic fill);
    widen_word = {{(XLEN-HALF){fill}}, v[HALF-1:0]};
  endfunction

  logic sign_bit;
  assign sign_bit = src[HALF-1];

  always_comb begin
    unique case (sel)
      SEL_SWORD: opnd = widen_word(src, sign_bit);
      SEL_UWORD: opnd = widen_word(src, 1'b0);
      default:   opnd = src;
    endcase
  end
endmodule

// File: rtl/saa_shift.sv
module saa_shift #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned SHW  = 2
) (
  input  logic [XLEN-1:0] opnd,
  input  logic [SHW-1:0]  sh,
  output logic [XLEN-1:0] shifted
);
  localparam int unsigned MW = SHW + 1;

  // biased amount with a guard bit so the increment cannot wrap
  function automatic logic [MW-1:0] biased_amt(input logic [SHW-1:0] s);
    biased_amt = {1'b0, s} + MW'(1);
  endfunction

  logic [MW-1:0]   amt;
  logic [XLEN-1:0] stage [MW+1];

  assign amt      = biased_amt(sh);
  assign stage[0] = opnd;

  genvar k;
  generate
    for (k = 0; k < MW; k++) begin : g_stage
      localparam int unsigned STEP = 1 << k;
      assign stage[k+1] = amt[k] ? {stage[k][XLEN-1-STEP:0], {STEP{1'b0}}}
                                 : stage[k];
    end
  endgenerate

  assign shifted = stage[MW];
endmodule

// File: rtl/saa_cc.sv
module saa_cc
  import saa_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0] val,
  output logic [CC_W-1:0] cc
);
  function automatic logic [CC_W-1:0] classify(input logic [XLEN-1:0] v);
    logic [CC_W-1:0] r;
    r         = '0;
    r[CC_NEG] = v[XLEN-1];
    r[CC_ZER] = (v == '0);
    r[CC_POS] = !v[XLEN-1] && (v != '0);
    r[CC_SO]  = 1'b0;
    classify  = r;
  endfunction

  assign cc = classify(val);
endmodule

// File: rtl/saa_unit.sv
module saa_unit
  import saa_pkg::*;
#(
  parameter int unsigned XLEN = 64,
  parameter int unsigned SHW  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            vld_in,
  input  logic [XLEN-1:0] base_in,
  input  logic [XLEN-1:0] idx_in,
  input  logic [SHW-1:0]  sh_in,
  input  logic [1:0]      sel_in,
  input  logic            rec_in,
  output logic [XLEN-1:0] sum_q,
  output logic            out_vld,
  output logic [3:0]      cond_q,
  output logic            cond_vld
);
  saa_sel_e        sel;
  logic [XLEN-1:0] opnd;
  logic [XLEN-1:0] shifted;
  logic [XLEN-1:0] sum_d;
  logic [CC_W-1:0] cc_d;

  assign sel = saa_sel_e'(sel_in);

  saa_extend #(.XLEN(XLEN)) u_ext (
    .src  (idx_in),
    .sel  (sel),
    .opnd (opnd)
  );

  saa_shift #(.XLEN(XLEN), .SHW(SHW)) u_shf (
    .opnd    (opnd),
    .sh      (sh_in),
    .shifted (shifted)
  );

  assign sum_d = base_in + shifted;

  saa_cc #(.XLEN(XLEN)) u_cc (
    .val (sum_d),
    .cc  (cc_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sum_q    <= '0;
      cond_q   <= '0;
      out_vld  <= 1'b0;
      cond_vld <= 1'b0;
    end else begin
      out_vld  <= vld_in;
      cond_vld <= vld_in && rec_in;
      if (vld_in) begin
        sum_q  <= sum_d;
        cond_q <= rec_in ? cc_d : '0;
      end
    end
  end

  // R6
  out_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld == $past(vld_in));

  // R6
  sum_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(vld_in) |-> $stable(sum_q));

  // R5
  lsb_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> sum_q[0] == $past(base_in[0]));

  // R7
  cond_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cond_vld |-> ($countones(cond_q[3:1]) == 1 && !cond_q[0]));

  // R7
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cond_vld |-> cond_q[1] == (sum_q == '0));

  // R8
  cond_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !cond_vld) |-> cond_q == 4'b0000);
endmodule

// File: tb/tb_saa_unit.sv
module tb_saa_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld_in = 1'b0;
  logic [63:0] base_in = '0;
  logic [63:0] idx_in = '0;
  logic [1:0]  sh_in = '0;
  logic [1:0]  sel_in = '0;
  logic        rec_in = 1'b0;
  logic [63:0] sum_q;
  logic        out_vld;
  logic [3:0]  cond_q;
  logic        cond_vld;

  int checks = 0;
  int errors = 0;
  logic [63:0] last_sum = '0;

  always #2.5 clk = ~clk;

  saa_unit dut (
    .clk(clk), .rst_n(rst_n), .vld_in(vld_in), .base_in(base_in),
    .idx_in(idx_in), .sh_in(sh_in), .sel_in(sel_in), .rec_in(rec_in),
    .sum_q(sum_q), .out_vld(out_vld), .cond_q(cond_q), .cond_vld(cond_vld)
  );

  // model: form operand, scale by a power of two, add
  function automatic logic [63:0] model_sum(input logic [63:0] a,
      input logic [63:0] b, input logic [1:0] sh, input logic [1:0] sel);
    logic [63:0] o;
    logic [63:0] scale;
    if (sel == 2'b01)      o = b[31] ? (b | 64'hFFFF_FFFF_0000_0000) : (b & 64'h0000_0000_FFFF_FFFF);
    else if (sel == 2'b10) o = b & 64'h0000_0000_FFFF_FFFF;
    else                   o = b;
    scale = 64'd2 ** (int'(sh) + 1);
    model_sum = a + o * scale;
  endfunction

  function automatic logic [3:0] model_cc(input logic [63:0] s);
    if ($signed(s) < 0)      model_cc = 4'b1000;
    else if ($signed(s) > 0) model_cc = 4'b0100;
    else                     model_cc = 4'b0010;
  endfunction

  task automatic check(input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input string req, input logic [63:0] a,
      input logic [63:0] b, input logic [1:0] sh, input logic [1:0] sel,
      input logic rec);
    logic [63:0] es;
    es = model_sum(a, b, sh, sel);
    @(negedge clk);
    base_in = a; idx_in = b; sh_in = sh; sel_in = sel; rec_in = rec;
    vld_in = 1'b1;
    @(negedge clk);
    vld_in = 1'b0;
    base_in = ~a; idx_in = ~b;
    check(req, sum_q, es);
    check("R6 out_vld", {63'd0, out_vld}, 64'd1);
    // R5: bit 0 carries through
    check("R5 lsb", {63'd0, sum_q[0]}, {63'd0, a[0]});
    if (rec) begin
      check("R7 cond_vld", {63'd0, cond_vld}, 64'd1);
      check("R7 cond", {60'd0, cond_q}, {60'd0, model_cc(es)});
    end else begin
      check("R8 cond_vld", {63'd0, cond_vld}, 64'd0);
      check("R8 cond", {60'd0, cond_q}, 64'd0);
    end
    @(negedge clk);
    check("R6 idle vld", {63'd0, out_vld}, 64'd0);
    check("R6 hold", sum_q, es);
  endtask

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] ra, rb;
    process::self().srandom(32'd4711);
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 sum", sum_q, 64'd0);
    check("R9 cond", {60'd0, cond_q}, 64'd0);
    check("R9 vld", {62'd0, out_vld, cond_vld}, 64'd0);
    rst_n = 1'b1;

    // R1 full operand, every shift
    for (int s = 0; s < 4; s++)
      run_op("R1 full", 64'h10, 64'h3, 2'(s), 2'b00, 1'b1);
    // R5 bits pushed out the top
    run_op("R5 overflow top", 64'h1, 64'hF000_0000_0000_0001, 2'd3, 2'b00, 1'b1);
    run_op("R5 top bit", 64'h0, 64'h8000_0000_0000_0000, 2'd0, 2'b00, 1'b1);
    // R2 signed word extremes
    run_op("R2 neg word", 64'h0, 64'h1234_5678_8000_0000, 2'd0, 2'b01, 1'b1);
    run_op("R2 all ones", 64'h2, 64'hFFFF_FFFF_FFFF_FFFF, 2'd0, 2'b01, 1'b1);
    run_op("R2 pos word", 64'h5, 64'hFFFF_FFFF_7FFF_FFFF, 2'd3, 2'b01, 1'b1);
    // R3 unsigned word
    run_op("R3 uword", 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 2'b10, 1'b1);
    run_op("R3 uword top", 64'h7, 64'hABCD_0000_8000_0000, 2'd1, 2'b10, 1'b0);
    // R4 alternate code
    run_op("R4 alt", 64'h100, 64'hDEAD_BEEF_0000_0001, 2'd2, 2'b11, 1'b1);
    // R7 zero result
    run_op("R7 zero", 64'hFFFF_FFFF_FFFF_FFFE, 64'h1, 2'd0, 2'b00, 1'b1);
    // R8 non-recording
    run_op("R8 norec", 64'h0, 64'h8000_0000_0000_0000, 2'd0, 2'b00, 1'b0);

    // random mix
    for (int i = 0; i < 300; i++) begin
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      run_op("R1 R2 R3 R4 random", ra, rb, 2'($urandom), 2'($urandom),
             1'($urandom));
    end

    // R9 reset mid-run clears outputs
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 sum again", sum_q, 64'd0);
    check("R9 vld again", {62'd0, out_vld, cond_vld}, 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule